// File: doc/BRIEF.md
# Two-Network Switch Allocator

This block is the switch allocator of a virtual-channel router whose output side serves two sub-networks. Each input port presents one request per virtual channel. A request names a direction and carries a one-bit network flag. A round-robin arbiter at each input picks one virtual channel. A multiplexer then pulls out that channel's direction and flag. A small selector turns the pair into one of eight output indices, so the choice of network is made in the control path and the flit datapath is never split.

A round-robin arbiter for each output then settles contention among inputs. Its result is written into registered crossbar selects and per-virtual-channel grants. An input's local priority moves past its winner only when that winner also wins the output it asked for. A losing channel therefore keeps first claim and retries on the next cycle.

Top module: `sa_top`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, every crossbar valid bit, every crossbar select field and every virtual-channel grant reads zero.
- R2: A request on input i, channel v (flat index i*2+v) that meets no contention appears one clock edge later. The crossbar valid bit for its output is set, that output's 2-bit select field holds i, and grant bit i*2+v is set.
- R3: The output index is the 2-bit direction when the network flag is 0. It is the direction plus 4 when the flag is 1. Output o's select field lives at bits [2*o+1:2*o].
- R4: When both channels of an input request and the input keeps winning, the winning channel alternates. Channel 0 is favoured first after reset.
- R5: If an input's chosen channel loses at the output stage, that input's channel priority is unchanged, so the same channel is chosen again on the next cycle.
- R6: Inputs competing for one output are served in round-robin order, starting after the input served last, with input 0 favoured first after reset.
- R7: Each output grants at most one input per cycle, and each input receives at most one channel grant per cycle.
- R8: Grant registers are rewritten every cycle. With no request, all valid bits and grants are zero one edge later, and select fields of outputs without a grant read zero.
- R9: Requests for the same direction on different networks do not contend and are granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 8 | Request per virtual channel, flat index input*2+channel |
| reqDir | input | 16 | 2-bit direction per virtual channel, same indexing |
| reqNet | input | 8 | Network flag per virtual channel (0: network 1, 1: network 2) |
| xbarValid | output | 8 | Registered crossbar enable per output |
| xbarSel | output | 16 | Registered 2-bit source input per output |
| vcGrant | output | 8 | Registered grant per virtual channel |

## Verification
All results come from a single register stage. Crossbar selects and channel grants for a request pattern applied between edges are therefore due right after the next rising edge. The priority changes that pattern causes show up in the pattern that follows. The driver applies each pattern at a falling edge and queues the expected outputs. The monitor pops one item just after each rising edge, so every comparison lands in the cycle the registers change. The expected values come from a priority model kept in the bench, which is advanced once per pattern.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int NUM_IN  = 4;
  localparam int NUM_VC  = 2;
  localparam int NUM_DIR = 4;
  localparam int NUM_NET = 2;
  localparam int NUM_OUT = NUM_DIR * NUM_NET;
  localparam int IN_W    = $clog2(NUM_IN);
  localparam int VC_W    = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;
  localparam int DIR_W   = $clog2(NUM_DIR);
  localparam int OUT_W   = $clog2(NUM_OUT);
  localparam int NREQ    = NUM_IN * NUM_VC;

  // Strobes from control to datapath: what to write into the grant registers.
  typedef struct packed {
    logic [NUM_OUT-1:0]            outGnt;
    logic [NUM_OUT-1:0][IN_W-1:0]  outSrc;
    logic [NUM_IN-1:0][NUM_VC-1:0] vcWin;
  } saStrobe_t;
endpackage

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import sa_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREQ-1:0]         reqValid,
  input  logic [NUM_IN*OUT_W-1:0] winOut,
  input  logic [NUM_IN-1:0]       winValid,
  output logic [NREQ-1:0]         localWin,
  output saStrobe_t               strobe
);
  logic [NUM_IN-1:0] gGnt [NUM_OUT];
  logic [NUM_IN-1:0] inWon;

  always_comb begin
    inWon = '0;
    for (int o = 0; o < NUM_OUT; o++) inWon = inWon | gGnt[o];
  end

  // Local stage: round robin over the channels of one input.
  for (genvar i = 0; i < NUM_IN; i++) begin : gLocal
    logic [VC_W-1:0]   ptr;
    logic [VC_W-1:0]   winIdx;
    logic [NUM_VC-1:0] pick;

    always_comb begin
      pick   = '0;
      winIdx = '0;
      for (int k = 0; k < NUM_VC; k++) begin
        if (pick == '0 && reqValid[i*NUM_VC + (int'(ptr) + 1 + k) % NUM_VC]) begin
          pick[(int'(ptr) + 1 + k) % NUM_VC] = 1'b1;
          winIdx = VC_W'((int'(ptr) + 1 + k) % NUM_VC);
        end
      end
    end

    assign localWin[i*NUM_VC +: NUM_VC] = pick;

    // Masking: priority moves only when the local winner was also served globally.
    always_ff @(posedge clk) begin
      if (rst)           ptr <= VC_W'(NUM_VC - 1);
      else if (inWon[i]) ptr <= winIdx;
    end
  end

  // Global stage: round robin over the inputs aiming at one output.
  for (genvar o = 0; o < NUM_OUT; o++) begin : gGlobal
    logic [IN_W-1:0]   ptr;
    logic [IN_W-1:0]   gIdx;
    logic [NUM_IN-1:0] want;
    logic [NUM_IN-1:0] pick;

    always_comb begin
      for (int i = 0; i < NUM_IN; i++)
        want[i] = winValid[i] && (winOut[i*OUT_W +: OUT_W] == OUT_W'(o));
    end

    always_comb begin
      pick = '0;
      gIdx = '0;
      for (int k = 0; k < NUM_IN; k++) begin
        if (pick == '0 && want[(int'(ptr) + 1 + k) % NUM_IN]) begin
          pick[(int'(ptr) + 1 + k) % NUM_IN] = 1'b1;
          gIdx = IN_W'((int'(ptr) + 1 + k) % NUM_IN);
        end
      end
    end

    assign gGnt[o] = pick;

    always_ff @(posedge clk) begin
      if (rst)        ptr <= IN_W'(NUM_IN - 1);
      else if (|pick) ptr <= gIdx;
    end
  end

  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      strobe.outGnt[o] = |gGnt[o];
      strobe.outSrc[o] = '0;
      for (int i = 0; i < NUM_IN; i++)
        if (gGnt[o][i]) strobe.outSrc[o] = IN_W'(i);
    end
    for (int i = 0; i < NUM_IN; i++)
      strobe.vcWin[i] = inWon[i] ? localWin[i*NUM_VC +: NUM_VC] : '0;
  end
endmodule

// File: rtl/sa_dpath.sv
module sa_dpath
  import sa_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREQ*DIR_W-1:0]    reqDir,
  input  logic [NREQ-1:0]          reqNet,
  input  logic [NREQ-1:0]          localWin,
  input  saStrobe_t                strobe,
  output logic [NUM_IN*OUT_W-1:0]  winOut,
  output logic [NUM_IN-1:0]        winValid,
  output logic [NUM_OUT-1:0]       xbarValid,
  output logic [NUM_OUT*IN_W-1:0]  xbarSel,
  output logic [NREQ-1:0]          vcGrant
);
  // Returns {carry, sum}.
  function automatic logic [1:0] halfAdd(input logic a, input logic b);
    return {a & b, a ^ b};
  endfunction

  for (genvar i = 0; i < NUM_IN; i++) begin : gSel
    logic [DIR_W-1:0] dirSel;
    logic             netSel;
    logic [OUT_W-1:0] xExt;
    logic [OUT_W-1:0] mapped;
    logic [OUT_W:0]   carry;

    // Winner multiplexer: forwards only the winning channel's port fields.
    always_comb begin
      dirSel = '0;
      netSel = 1'b0;
      for (int v = 0; v < NUM_VC; v++) begin
        if (localWin[i*NUM_VC + v]) begin
          dirSel = dirSel | reqDir[(i*NUM_VC + v)*DIR_W +: DIR_W];
          netSel = netSel | reqNet[i*NUM_VC + v];
        end
      end
    end

    // Network selector: index = direction + flag * NUM_DIR, a chain of half adders.
    always_comb begin
      xExt     = {{(OUT_W-DIR_W){1'b0}}, dirSel};
      carry[0] = 1'b0;
      for (int b = 0; b < OUT_W; b++)
        {carry[b+1], mapped[b]} = halfAdd(xExt[b], (b == DIR_W) ? netSel : carry[b]);
    end

    assign winOut[i*OUT_W +: OUT_W] = mapped;
    assign winValid[i]              = |localWin[i*NUM_VC +: NUM_VC];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xbarValid <= '0;
      xbarSel   <= '0;
      vcGrant   <= '0;
    end else begin
      xbarValid <= strobe.outGnt;
      xbarSel   <= strobe.outSrc;
      vcGrant   <= strobe.vcWin;
    end
  end
endmodule

// File: rtl/sa_top.sv
module sa_top
  import sa_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREQ-1:0]         reqValid,
  input  logic [NREQ*DIR_W-1:0]   reqDir,
  input  logic [NREQ-1:0]         reqNet,
  output logic [NUM_OUT-1:0]      xbarValid,
  output logic [NUM_OUT*IN_W-1:0] xbarSel,
  output logic [NREQ-1:0]         vcGrant
);
  logic [NREQ-1:0]         localWin;
  logic [NUM_IN*OUT_W-1:0] winOut;
  logic [NUM_IN-1:0]       winValid;
  saStrobe_t               strobe;

  sa_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .winOut(winOut),
    .winValid(winValid), .localWin(localWin), .strobe(strobe)
  );

  sa_dpath u_dpath (
    .clk(clk), .rst(rst), .reqDir(reqDir), .reqNet(reqNet),
    .localWin(localWin), .strobe(strobe), .winOut(winOut), .winValid(winValid),
    .xbarValid(xbarValid), .xbarSel(xbarSel), .vcGrant(vcGrant)
  );
endmodule

// File: rtl/sa_checker.sv
module sa_checker
  import sa_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic [NREQ-1:0]         reqValid,
  input logic [NREQ*DIR_W-1:0]   reqDir,
  input logic [NREQ-1:0]         reqNet,
  input logic [NUM_OUT-1:0]      xbarValid,
  input logic [NUM_OUT*IN_W-1:0] xbarSel,
  input logic [NREQ-1:0]         vcGrant
);
  logic [NUM_IN-1:0] hit  [NUM_OUT];
  logic [NUM_IN-1:0] hitQ [NUM_OUT];
  int                srcCnt [NUM_IN];

  // hit[o][i]: some channel of input i asks for output o this cycle.
  always_comb begin
    for (int o = 0; o < NUM_OUT; o++)
      for (int i = 0; i < NUM_IN; i++) begin
        hit[o][i] = 1'b0;
        for (int v = 0; v < NUM_VC; v++)
          if (reqValid[i*NUM_VC+v] &&
              reqDir[(i*NUM_VC+v)*DIR_W +: DIR_W] == DIR_W'(o % NUM_DIR) &&
              reqNet[i*NUM_VC+v] == ((o / NUM_DIR) != 0))
            hit[o][i] = 1'b1;
      end
  end

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      srcCnt[i] = 0;
      for (int o = 0; o < NUM_OUT; o++)
        if (xbarValid[o] && xbarSel[o*IN_W +: IN_W] == IN_W'(i)) srcCnt[i]++;
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < NUM_OUT; o++) hitQ[o] <= rst ? '0 : hit[o];
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (xbarValid == '0 && xbarSel == '0 && vcGrant == '0)); // R1

  for (genvar o = 0; o < NUM_OUT; o++) begin : gOut
    AST_OUT_MATCHES_REQUEST: assert property (@(posedge clk) disable iff (rst)
      xbarValid[o] |-> hitQ[o][xbarSel[o*IN_W +: IN_W]]); // R3
  end

  for (genvar k = 0; k < NREQ; k++) begin : gReq
    AST_NO_GRANT_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
      !reqValid[k] |=> !vcGrant[k]); // R8
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : gIn
    AST_ONE_VC_PER_INPUT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(vcGrant[i*NUM_VC +: NUM_VC])); // R7
    AST_ONE_OUTPUT_PER_INPUT: assert property (@(posedge clk) disable iff (rst)
      srcCnt[i] == $countones(vcGrant[i*NUM_VC +: NUM_VC])); // R7
  end
endmodule

bind sa_top sa_checker u_sa_checker (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqDir(reqDir), .reqNet(reqNet),
  .xbarValid(xbarValid), .xbarSel(xbarSel), .vcGrant(vcGrant)
);

// File: tb/sa_top_bench.sv
`timescale 1ns/1ps
module sa_top_bench;
  import sa_pkg::*;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [NREQ-1:0]         reqValid = '0;
  logic [NREQ*DIR_W-1:0]   reqDir = '0;
  logic [NREQ-1:0]         reqNet = '0;
  logic [NUM_OUT-1:0]      xbarValid;
  logic [NUM_OUT*IN_W-1:0] xbarSel;
  logic [NREQ-1:0]         vcGrant;

  always #2 clk = ~clk;  // 250 MHz

  sa_top u_sa_top (.*);

  typedef struct {
    logic [NUM_OUT-1:0]      xv;
    logic [NUM_OUT*IN_W-1:0] xs;
    logic [NREQ-1:0]         vg;
    string                   tag;
  } expItem_t;

  expItem_t q[$];
  int checks = 0;
  int errors = 0;
  int lp [NUM_IN];
  int gp [NUM_OUT];
  logic [NREQ-1:0]       tv;
  logic [NREQ*DIR_W-1:0] td;
  logic [NREQ-1:0]       tn;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr();
    tv = '0; td = '0; tn = '0;
  endtask

  task automatic put(input int k, input int dir, input bit net);
    tv[k] = 1'b1;
    td[k*DIR_W +: DIR_W] = DIR_W'(dir);
    tn[k] = net;
  endtask

  // Apply a pattern at a falling edge and queue what the registers must hold after the next rising edge.
  task automatic drive(input string tag);
    int win [NUM_IN];
    int tgt [NUM_IN];
    expItem_t e;
    @(negedge clk);
    reqValid = tv; reqDir = td; reqNet = tn;
    e.xv = '0; e.xs = '0; e.vg = '0; e.tag = tag;
    for (int i = 0; i < NUM_IN; i++) begin
      win[i] = -1;
      tgt[i] = -1;
      for (int k = 0; k < NUM_VC; k++) begin
        int idx = (lp[i] + 1 + k) % NUM_VC;
        if (win[i] < 0 && tv[i*NUM_VC+idx]) win[i] = idx;
      end
      if (win[i] >= 0)
        tgt[i] = int'(td[(i*NUM_VC+win[i])*DIR_W +: DIR_W]) + NUM_DIR * int'(tn[i*NUM_VC+win[i]]);
    end
    for (int o = 0; o < NUM_OUT; o++) begin
      int g = -1;
      for (int k = 0; k < NUM_IN; k++) begin
        int i = (gp[o] + 1 + k) % NUM_IN;
        if (g < 0 && win[i] >= 0 && tgt[i] == o) g = i;
      end
      if (g >= 0) begin
        e.xv[o] = 1'b1;
        e.xs[o*IN_W +: IN_W] = IN_W'(g);
        e.vg[g*NUM_VC + win[g]] = 1'b1;
        gp[o] = g;
        lp[g] = win[g];
      end
    end
    q.push_back(e);
  endtask

  // Monitor: compares just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      chk({e.tag, " xbarValid"}, 32'(xbarValid), 32'(e.xv));
      chk({e.tag, " xbarSel"},   32'(xbarSel),   32'(e.xs));
      chk({e.tag, " vcGrant"},   32'(vcGrant),   32'(e.vg));
    end
  end

  bit finished = 0;

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_IN; i++) lp[i] = NUM_VC - 1;
    for (int o = 0; o < NUM_OUT; o++) gp[o] = NUM_IN - 1;
    clr();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 xbarValid in reset", 32'(xbarValid), 0);
    chk("R1 vcGrant in reset", 32'(vcGrant), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 xbarValid after reset", 32'(xbarValid), 0);
    chk("R1 xbarSel after reset", 32'(xbarSel), 0);
    chk("R1 vcGrant after reset", 32'(vcGrant), 0);

    // R2: lone request, network 1
    clr(); put(0, 2, 1'b0); drive("R2 single");
    clr(); put(7, 3, 1'b0); drive("R2 input3 vc1");
    // R3: network 2 remap
    clr(); put(5, 1, 1'b1); drive("R3 net2");
    clr(); put(2, 3, 1'b1); drive("R3 net2 top");
    // R9: same direction, both networks
    clr(); put(0, 1, 1'b0); put(2, 1, 1'b1); drive("R9 split");
    // R6: four inputs on one output
    for (int c = 0; c < 6; c++) begin
      clr();
      for (int i = 0; i < NUM_IN; i++) put(i*NUM_VC, 3, 1'b0);
      drive("R6 rotate");
    end
    // R4: both channels of input 1, no contention
    for (int c = 0; c < 4; c++) begin
      clr(); put(2, 0, 1'b0); put(3, 2, 1'b0); drive("R4 alternate");
    end
    // R5: local winner loses globally and retries
    for (int c = 0; c < 5; c++) begin
      clr(); put(0, 0, 1'b0); put(1, 2, 1'b1); put(2, 0, 1'b0); put(4, 0, 1'b0);
      drive("R5 retry");
    end
    // R8: idle clears
    clr(); drive("R8 idle");
    clr(); drive("R8 idle again");
    // R7: mixed patterns
    for (int c = 0; c < 60; c++) begin
      tv = NREQ'($urandom); td = (NREQ*DIR_W)'($urandom); tn = NREQ'($urandom);
      drive("R7 mixed");
    end
    clr(); drive("R8 final idle");
    @(posedge clk); #2;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule